// File: doc/BRIEF.md
# Instruction-Tracking Stage Gating Controller

This block follows one chosen instruction class through a five-stage, single-issue integer pipeline (fetch, decode, execute, memory, writeback). For every stage it raises a presence flag while an instance of the tracked instruction occupies that stage. The fetch flag comes from an opcode compare on the fetched word. Each later flag is the earlier stage's flag, registered for one clock and qualified by that stage's own freeze.

The flags then drive a vector of unit run-enables. An enable is pulled low, so that the surrounding logic can hold that unit idle, only while the tracked instruction sits in the stage that owns the unit. A parameter mask states which units each stage may idle. Units outside every stage's mask are never idled. The enables are meant to feed clock-gate or operand-isolation cells elsewhere. Gating must never change the pipeline's architectural results, so an enable must not drop while any other instruction might still need that unit.

Top module: `stage_gate_ctrl`

## Requirements
- R1: After reset is released, and before any tracked opcode is fetched, all five flags read 0 and all 16 bits of `unit_run` read 1.
- R2: `stage_flag[0]` (fetch) is 1 in the same cycle exactly when `instr[31:26]` equals 6'b111000, `rst` is 0, `flush` is 0 and `freeze[0]` is 0.
- R3: For stage s from 1 to 4 (bit s of `stage_flag`: 1 decode, 2 execute, 3 memory, 4 writeback), the flag equals the value `stage_flag[s-1]` had one clock earlier, ANDed with the inverse of `freeze[s]`.
- R4: While `flush` is 1, all five flags read 0 in that same cycle.
- R5: While `rst` is 1, all flags read 0. The flag registers clear at a clock edge where `rst` is 1.
- R6: With the default mask, fetch may idle units 0 and 1, decode units 2 and 3, execute units 4 and 5, memory units 6 and 7, and writeback units 8 and 9. `unit_run[u]` is 0 exactly when the flag of the stage that owns u is 1.
- R7: Units 10 to 15 belong to no stage and always read 1. When no flag is set, every unit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word in the fetch stage |
| flush | input | 1 | Pipeline flush; clears every stage flag |
| freeze | input | 5 | Per-stage freeze, bit 0 fetch through bit 4 writeback |
| stage_flag | output | 5 | Tracked instruction present, bit 0 fetch through bit 4 writeback |
| unit_run | output | 16 | Per-unit run-enable; 0 means the unit may be held idle |

## Verification
The chain assertions assume that `rst` is high at time zero and for at least one clock edge. This makes every registered flag a known 0 before any `$past` comparison is made. The stimulus holds reset for several cycles before it releases it. The assertions also assume that `freeze` and `flush` change only away from the sampling edge. The bench drives every input on the falling edge. The random stream mixes tracked and untracked opcodes with random per-stage freezes and occasional flushes, so that every gating path is exercised. Directed runs cover a clean walk of one tracked instruction, a flush while that instruction is in flight, and a reset asserted in mid-stream.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int NUM_STAGES = 5;
  localparam int STG_FETCH  = 0;
  localparam int STG_WB     = NUM_STAGES - 1;

  // next flag of a later stage: delayed predecessor, own freeze, global kills
  function automatic logic chain_next(input logic prev_q, input logic frz,
                                      input logic kill);
    return prev_q & ~frz & ~kill;
  endfunction
endpackage

// File: rtl/sgc_match.sv
module sgc_match #(
  parameter int          WORD_W  = 32,
  parameter int          OPC_LSB = 26,
  parameter int          OPC_W   = 6,
  parameter logic [5:0]  OPC_VAL = 6'b111000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr,
  input  logic              flush,
  input  logic              frz_fetch,
  output logic              hit
);
  localparam int OPC_MSB = OPC_LSB + OPC_W - 1;

  function automatic logic opc_equal(input logic [WORD_W-1:0] w);
    return w[OPC_MSB:OPC_LSB] == OPC_VAL[OPC_W-1:0];
  endfunction

  logic opc_hit;
  logic fetch_kill;
  assign opc_hit    = opc_equal(instr);
  assign fetch_kill = rst | flush | frz_fetch;
  assign hit        = opc_hit & ~fetch_kill;

  // R2: a fetch hit never appears on a non-matching or frozen word
  p_fetch_opcode_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> (instr[OPC_MSB:OPC_LSB] == OPC_VAL[OPC_W-1:0]) && !frz_fetch);
  // R4: flush kills the fetch hit
  p_fetch_flush_r4: assert property (@(posedge clk) disable iff (rst)
    flush |-> !hit);
endmodule

// File: rtl/sgc_track.sv
module sgc_track
  import sgc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  hit0,
  input  logic [NUM_STAGES-1:1] frz_late,
  output logic [NUM_STAGES-1:0] flags
);
  logic [NUM_STAGES-1:0] flag_q;
  logic                  kill;

  assign kill                = rst | flush;
  assign flags[STG_FETCH]    = hit0 & ~kill;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flags;
  end

  for (genvar s = 1; s < NUM_STAGES; s++) begin : g_chain
    assign flags[s] = chain_next(flag_q[s-1], frz_late[s], kill);

    // R3: a later flag only follows a set predecessor, and always does unless frozen
    p_chain_src_r3: assert property (@(posedge clk) disable iff (rst)
      flags[s] |-> $past(flags[s-1]) && !frz_late[s]);
    p_chain_fwd_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(flags[s-1]) && !frz_late[s] && !flush) |-> flags[s]);
  end

  // R4: flush empties every stage at once
  p_flush_all_r4: assert property (@(posedge clk) disable iff (rst)
    flush |-> (flags == '0));
  // R5: first cycle out of reset carries nothing into later stages
  p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flags[NUM_STAGES-1:1] == '0));
endmodule

// File: rtl/sgc_enmap.sv
module sgc_enmap
  import sgc_pkg::*;
#(
  parameter int                           N_UNITS = 16,
  parameter logic [NUM_STAGES*N_UNITS-1:0] STAGE_UNIT_MASK = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_STAGES-1:0] flags,
  output logic [N_UNITS-1:0]    unit_run
);
  // units that some stage is permitted to idle
  function automatic logic [N_UNITS-1:0] gateable_set();
    logic [N_UNITS-1:0] acc;
    acc = '0;
    for (int s = 0; s < NUM_STAGES; s++)
      acc |= STAGE_UNIT_MASK[s*N_UNITS +: N_UNITS];
    return acc;
  endfunction

  localparam logic [N_UNITS-1:0] GATEABLE = gateable_set();

  logic [NUM_STAGES-1:0][N_UNITS-1:0] stage_idle;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign stage_idle[s] = {N_UNITS{flags[s]}} & STAGE_UNIT_MASK[s*N_UNITS +: N_UNITS];

    // R6: a flagged stage idles every unit it owns
    p_stage_idle_r6: assert property (@(posedge clk) disable iff (rst)
      flags[s] |-> ((unit_run & STAGE_UNIT_MASK[s*N_UNITS +: N_UNITS]) == '0));
  end

  always_comb begin
    unit_run = '1;
    for (int s = 0; s < NUM_STAGES; s++)
      unit_run &= ~stage_idle[s];
  end

  // R7: units owned by no stage never drop; no flag means everything runs
  p_outside_run_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(~unit_run & ~GATEABLE) == 0);
  p_idle_run_r7: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |-> (unit_run == '1));
endmodule

// File: rtl/stage_gate_ctrl.sv
module stage_gate_ctrl
  import sgc_pkg::*;
#(
  parameter int          WORD_W  = 32,
  parameter int          OPC_LSB = 26,
  parameter int          OPC_W   = 6,
  parameter logic [5:0]  OPC_VAL = 6'b111000,
  parameter int          N_UNITS = 16,
  parameter logic [NUM_STAGES*N_UNITS-1:0] STAGE_UNIT_MASK =
    {16'h0300, 16'h00C0, 16'h0030, 16'h000C, 16'h0003}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     instr,
  input  logic                  flush,
  input  logic [NUM_STAGES-1:0] freeze,
  output logic [NUM_STAGES-1:0] stage_flag,
  output logic [N_UNITS-1:0]    unit_run
);
  logic fetch_hit;

  sgc_match #(
    .WORD_W(WORD_W), .OPC_LSB(OPC_LSB), .OPC_W(OPC_W), .OPC_VAL(OPC_VAL)
  ) u_match (
    .clk(clk), .rst(rst), .instr(instr), .flush(flush),
    .frz_fetch(freeze[STG_FETCH]), .hit(fetch_hit)
  );

  sgc_track u_track (
    .clk(clk), .rst(rst), .flush(flush), .hit0(fetch_hit),
    .frz_late(freeze[NUM_STAGES-1:1]), .flags(stage_flag)
  );

  sgc_enmap #(
    .N_UNITS(N_UNITS), .STAGE_UNIT_MASK(STAGE_UNIT_MASK)
  ) u_enmap (
    .clk(clk), .rst(rst), .flags(stage_flag), .unit_run(unit_run)
  );

  // R5: reset holds every flag low
  p_reset_flags_r5: assert property (@(posedge clk) rst |-> (stage_flag == '0));
endmodule

// File: tb/sim_stage_gate_ctrl.sv
`timescale 1ns/100ps
module sim_stage_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        flush = 1'b0;
  logic [4:0]  freeze = '0;
  logic [4:0]  stage_flag;
  logic [15:0] unit_run;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [4:0] ref_prev = '0;

  always #2.5 clk = ~clk;

  stage_gate_ctrl u0 (
    .clk(clk), .rst(rst), .instr(instr), .flush(flush),
    .freeze(freeze), .stage_flag(stage_flag), .unit_run(unit_run)
  );

  localparam logic [5:0] TRK = 6'b111000;

  function automatic logic [4:0] model_flags(logic [31:0] w, logic r, logic fl,
                                             logic [4:0] fz, logic [4:0] prev);
    logic [4:0] f;
    f[0] = (w[31:26] == TRK) && !r && !fl && !fz[0];
    for (int s = 1; s < 5; s++) f[s] = prev[s-1] && !fz[s] && !r && !fl;
    return f;
  endfunction

  // stage s owns units 2s and 2s+1; units 10..15 belong to no stage
  function automatic logic [15:0] model_run(logic [4:0] f);
    logic [15:0] e = '1;
    for (int u = 0; u < 10; u++) if (f[u/2]) e[u] = 1'b0;
    return e;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [31:0] w, logic r, logic fl, logic [4:0] fz);
    logic [4:0] ef;
    string ftag;
    @(negedge clk);
    instr = w; rst = r; flush = fl; freeze = fz;
    #1;
    ef = model_flags(w, r, fl, fz, ref_prev);
    ftag = r ? "R5" : (fl ? "R4" : ((w[31:26] == TRK) ? "R2" : "R3"));
    check(ftag, {11'd0, stage_flag}, {11'd0, ef});
    check((ef == 0) ? "R7" : "R6", unit_run, model_run(ef));
    @(posedge clk);
    ref_prev = r ? 5'd0 : ef;
  endtask

  function automatic logic [31:0] word(bit tracked, logic [31:0] rnd);
    logic [5:0] op;
    op = tracked ? TRK : ((rnd[31:26] == TRK) ? 6'b000001 : rnd[31:26]);
    return {op, rnd[25:0]};
  endfunction

  initial begin
    #(2000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0051);
    for (int i = 0; i < 4; i++) step(word(1, 32'h0), 1'b1, 1'b0, 5'd0);
    // R1: idle state right after reset
    step(word(0, 32'h1234_5678), 1'b0, 1'b0, 5'd0);
    @(negedge clk); #1;
    check("R1", {11'd0, stage_flag}, 16'd0);
    check("R1", unit_run, 16'hFFFF);
    // clean walk of one tracked instruction through all stages (R3, R6)
    step(word(1, 32'h0000_00AA), 1'b0, 1'b0, 5'd0);
    for (int i = 0; i < 6; i++) step(word(0, 32'h0400_0000), 1'b0, 1'b0, 5'd0);
    // flush with a tracked instruction in flight (R4)
    step(word(1, 32'h0), 1'b0, 1'b0, 5'd0);
    step(word(1, 32'h0), 1'b0, 1'b0, 5'd0);
    step(word(1, 32'h0), 1'b0, 1'b1, 5'd0);
    step(word(0, 32'h0), 1'b0, 1'b0, 5'd0);
    // fetch freeze blocks a tracked word (R2), decode freeze drops it (R3)
    step(word(1, 32'h0), 1'b0, 1'b0, 5'b00001);
    step(word(1, 32'h0), 1'b0, 1'b0, 5'b00000);
    step(word(0, 32'h0), 1'b0, 1'b0, 5'b00010);
    // reset in mid-stream (R5)
    step(word(1, 32'h0), 1'b0, 1'b0, 5'd0);
    step(word(1, 32'h0), 1'b1, 1'b0, 5'd0);
    step(word(0, 32'h0), 1'b0, 1'b0, 5'd0);
    // random stream
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] rnd;
      logic [4:0]  fz;
      rnd = $urandom;
      fz  = 5'd0;
      for (int s = 0; s < 5; s++) fz[s] = ($urandom % 5) == 0;
      step(word(($urandom % 2) == 0, rnd), ($urandom % 200) == 0,
           ($urandom % 20) == 0, fz);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule